// File: doc/BRIEF.md
# Four-Channel Reloading Interval Timer

This block holds four independent interval timers behind a small register bus. Each channel has a base register and a read-only live count. The live count decrements on a shared tick. The tick comes from a prescaler that divides the block clock by 4 or 8, which gives a nominal 25 MHz tick from a 100 MHz or 200 MHz board clock.

Bit 31 of a channel's base register is a count-inhibit flag, and the channel counts only while that flag is clear. A tick that finds the live count at zero is an expiry. On expiry the channel reloads the count from the base value, inverts a toggle status bit, and pulses its own interrupt line for one cycle.

Software starts a channel by writing a base value with the inhibit flag clear. It stops the channel by writing the flag set again. The rest of the interrupt system consumes the four pulse lines. Routing and acknowledge are handled elsewhere.

Top module: `tmr_bank`

## Requirements
- R1: The address decodes as follows. addr[7:6] selects the channel. addr[5:4] selects the register: 0 is the live count and 1 is the base. An access with addr[3:0] not zero, or with addr[5:4] equal to 2 or 3, is unmapped: a write to it does nothing.
- R2: A read returns its data on rdata in the cycle after rd_en, taken from the register state before that clock edge. rdata is zero in any cycle that follows one without rd_en, and a read of an unmapped location returns zero.
- R3: The prescaler issues one tick every 4 clocks when div_sel=0 and every 8 clocks when div_sel=1.
- R4: While base bit 31 (inhibit) is set, the channel neither counts nor pulses its interrupt.
- R5: A base write that takes inhibit from 1 to 0 sets the live count to wdata[30:0] and clears the toggle bit.
- R6: A base write that takes inhibit from 0 to 1 clears the live count to zero and keeps the toggle bit.
- R7: A base write that leaves inhibit unchanged replaces the stored base and leaves the live count and toggle untouched by the write.
- R8: On a tick with inhibit clear, a nonzero count decrements by one. A count of zero reloads from base[30:0], inverts the toggle, and raises irq[channel] for exactly one cycle. The period is therefore base+1 ticks.
- R9: A base value of zero with inhibit clear gives an interrupt pulse on every tick.
- R10: After reset, every base register reads 0x8000_0000 and every live count reads zero.
- R11: A live count read returns the toggle in bit 31 and the count in bits [30:0].
- R12: Writes to the live count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 1 | Prescaler select: 0 divides by 4, 1 divides by 8 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | One-cycle expiry pulse per channel |

## Verification
A write takes effect at the clock edge where it is presented. A read of that effect must therefore be issued in a later cycle, and its data is sampled on the falling edge after the next rising edge. An interrupt pulse appears in the cycle that follows the tick edge on which the expiry happens. The bench keeps a cycle model that updates on the same rising edges as the design and compares irq and rdata on every falling edge. Directed checks on pulse spacing count whole cycles between pulse-visible falling edges, and they measure the second interval after any rate change so that the prescaler phase cannot skew the result.

// File: rtl/tmr_pkg.sv
// Package: shared sizes and register offset codes for the timer bank.
// Assumes a 32-bit data bus with the inhibit flag in the top bit.
package tmr_pkg;
    parameter int NUM_CH  = 4;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 8;
    parameter int IDX_LSB = 6;
    parameter int OFS_LSB = 4;
    parameter int PS_W    = 3;

    localparam int IDX_W  = $clog2(NUM_CH);
    localparam int OFS_W  = 2;
    localparam int CNT_W  = DATA_W - 1;
    localparam int INH    = DATA_W - 1;
    localparam int LOW_W  = OFS_LSB;

    typedef enum logic [OFS_W-1:0] {
        OFS_CUR  = 2'd0,
        OFS_BASE = 2'd1,
        OFS_NA2  = 2'd2,
        OFS_NA3  = 2'd3
    } reg_ofs_e;

    localparam logic [DATA_W-1:0] BASE_RST = {1'b1, {CNT_W{1'b0}}};
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: produces a one-cycle tick every 4 or 8 clocks.
// Assumes div_sel may change at any time; an overshot count ticks at once.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    output logic tick
);
    localparam logic [PS_W-1:0] LAST_FAST = PS_W'(3);
    localparam logic [PS_W-1:0] LAST_SLOW = PS_W'(7);

    logic [PS_W-1:0] ps_cnt;
    logic [PS_W-1:0] ps_last;

    // Pick the terminal phase and flag the tick.
    always_comb begin
        ps_last = div_sel ? LAST_SLOW : LAST_FAST;
        tick    = (ps_cnt >= ps_last);
    end

    // Advance the phase counter, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_cnt <= '0;
        end else if (tick) begin
            ps_cnt <= '0;
        end else begin
            ps_cnt <= ps_cnt + PS_W'(1);
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// Channel: one base register, live down-counter, toggle bit and pulse.
// Assumes base_we is a single-cycle strobe already decoded for this channel.
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              base_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] cur_q,
    output logic              inh,
    output logic              tog,
    output logic              irq
);
    logic [CNT_W-1:0] cnt;
    logic             start_w;
    logic             stop_w;
    logic             step;
    logic             expire;

    // Classify this cycle's write and the count step.
    always_comb begin
        inh     = base_q[INH];
        start_w = base_we &&  base_q[INH] && !wdata[INH];
        stop_w  = base_we && !base_q[INH] &&  wdata[INH];
        step    = !base_q[INH] && tick && !start_w && !stop_w;
        expire  = step && (cnt == '0);
        cur_q   = {tog, cnt};
    end

    // Base register: any decoded write replaces the whole word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_RST;
        end else if (base_we) begin
            base_q <= wdata;
        end
    end

    // Live count and toggle: start, stop, reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            tog <= 1'b0;
        end else if (start_w) begin
            cnt <= wdata[CNT_W-1:0];
            tog <= 1'b0;
        end else if (stop_w) begin
            cnt <= '0;
        end else if (expire) begin
            cnt <= base_q[CNT_W-1:0];
            tog <= ~tog;
        end else if (step) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Interrupt pulse: high for the cycle after an expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= expire;
        end
    end
endmodule

// File: rtl/tmr_regif.sv
// Register interface: decodes writes to base strobes, muxes registered reads.
// Assumes single-cycle accesses; low address bits must be zero to hit.
module tmr_regif
    import tmr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0] cur_q,
    input  logic [NUM_CH-1:0][DATA_W-1:0] base_q,
    output logic [NUM_CH-1:0]             base_we,
    output logic [DATA_W-1:0]             rdata
);
    logic [IDX_W-1:0] idx;
    reg_ofs_e         ofs;
    logic             aligned;
    logic [DATA_W-1:0] rd_mux;

    // Split the address into channel, register and alignment.
    always_comb begin
        idx     = addr[IDX_LSB +: IDX_W];
        ofs     = reg_ofs_e'(addr[OFS_LSB +: OFS_W]);
        aligned = (addr[LOW_W-1:0] == '0);
    end

    // Base write strobes, one per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_we
        assign base_we[g] = wr_en && aligned && (ofs == OFS_BASE) &&
                            (idx == IDX_W'(g));
    end

    // Read multiplexer over the mapped registers.
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (ofs)
                OFS_CUR:  rd_mux = cur_q[idx];
                OFS_BASE: rd_mux = base_q[idx];
                default:  rd_mux = '0;
            endcase
        end
    end

    // Registered read data, zero when no read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/tmr_bank.sv
// Top: four reloading down-counters sharing one prescaled tick.
// Assumes a synchronous bus with one access per cycle at most.
module tmr_bank
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);
    logic                          tick;
    logic [NUM_CH-1:0]             base_we;
    logic [NUM_CH-1:0][DATA_W-1:0] cur_q;
    logic [NUM_CH-1:0][DATA_W-1:0] base_q;
    logic [NUM_CH-1:0]             ch_inh;
    logic [NUM_CH-1:0]             ch_tog;

    tmr_prescaler u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (tick)
    );

    tmr_regif u_rif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .cur_q   (cur_q),
        .base_q  (base_q),
        .base_we (base_we),
        .rdata   (rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .base_we (base_we[g]),
            .wdata   (wdata),
            .base_q  (base_q[g]),
            .cur_q   (cur_q[g]),
            .inh     (ch_inh[g]),
            .tog     (ch_tog[g]),
            .irq     (irq[g])
        );
    end
endmodule

// File: rtl/tmr_bank_chk.sv
// Checker: temporal properties of the timer bank, bound into tmr_bank.
// Assumes it sees the shared tick and per-channel inhibit and toggle.
module tmr_bank_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] ch_inh,
    input logic [NUM_CH-1:0] ch_tog
);
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0)); // R2

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

    for (genvar g = 0; g < NUM_CH; g++) begin : g_p
        AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |=> !irq[g]); // R8

        AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(tick)); // R3

        AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ch_inh[g] |=> !irq[g]); // R4

        AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> (ch_tog[g] != $past(ch_tog[g]))); // R8
    end
endmodule

bind tmr_bank tmr_bank_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .rd_en  (rd_en),
    .rdata  (rdata),
    .irq    (irq),
    .ch_inh (ch_inh),
    .ch_tog (ch_tog)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int total = 0;
    int bad = 0;

    tmr_bank dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Reference model state, updated on the same rising edges.
    logic [2:0]  m_ps;
    logic [30:0] m_cnt [4];
    logic        m_tog [4];
    logic [31:0] m_base [4];
    logic [3:0]  m_irq;
    logic [31:0] m_rdata;

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a[3:0] != 4'd0) return 32'd0;
        if (a[5:4] == 2'd0) return {m_tog[a[7:6]], m_cnt[a[7:6]]};
        if (a[5:4] == 2'd1) return m_base[a[7:6]];
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ps <= 0; m_irq <= 0; m_rdata <= 0;
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] <= 0; m_tog[i] <= 0; m_base[i] <= 32'h8000_0000;
            end
        end else begin
            logic tk;
            tk = (m_ps >= (div_sel ? 3'd7 : 3'd3));
            m_ps <= tk ? 3'd0 : m_ps + 3'd1;
            m_rdata <= rd_en ? exp_read(addr) : 32'd0;
            for (int i = 0; i < 4; i++) begin
                logic we, oi;
                we = wr_en && addr[3:0] == 0 && addr[5:4] == 1 && addr[7:6] == i;
                oi = m_base[i][31];
                m_irq[i] <= 1'b0;
                if (we) m_base[i] <= wdata;
                if (we && oi && !wdata[31]) begin
                    m_cnt[i] <= wdata[30:0]; m_tog[i] <= 1'b0;
                end else if (we && !oi && wdata[31]) begin
                    m_cnt[i] <= 0;
                end else if (!oi && tk) begin
                    if (m_cnt[i] == 0) begin
                        m_cnt[i] <= m_base[i][30:0];
                        m_tog[i] <= ~m_tog[i];
                        m_irq[i] <= 1'b1;
                    end else begin
                        m_cnt[i] <= m_cnt[i] - 31'd1;
                    end
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Continuous comparison against the model on falling edges.
    bit mon_on = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R8 irq lines", {28'd0, irq}, {28'd0, m_irq});
            chk("R2 read data", rdata, m_rdata);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; addr = a;
        @(negedge clk);
        d = rdata;
        rd_en = 0;
    endtask

    task automatic wait_pulse(int ch);
        int lim = 0;
        do begin
            @(negedge clk); lim++;
        end while (!irq[ch] && lim < 500);
    endtask

    task automatic gap(int ch, output int g);
        wait_pulse(ch);
        g = 0;
        do begin
            @(negedge clk); g++;
        end while (!irq[ch] && g < 500);
    endtask

    initial begin
        #(5ns * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int g, pulses;
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        mon_on = 1;

        // R10 reset state
        for (int i = 0; i < 4; i++) begin
            do_rd(8'(i << 6) | 8'h10, v); chk("R10 base reset", v, 32'h8000_0000);
            do_rd(8'(i << 6), v);         chk("R10 count reset", v, 32'h0);
        end
        // R1 decode with inhibit kept set (R7 path)
        do_wr(8'h90, 32'h8000_0123);
        do_rd(8'h90, v); chk("R1 ch2 base", v, 32'h8000_0123);
        do_rd(8'h50, v); chk("R1 ch1 base untouched", v, 32'h8000_0000);
        do_rd(8'h94, v); chk("R1 misaligned reads zero", v, 32'h0);
        do_wr(8'h58, 32'h0000_0007);
        do_rd(8'h50, v); chk("R1 misaligned write ignored", v, 32'h8000_0000);
        // R2 unmapped offsets
        do_rd(8'hA0, v); chk("R2 offset 2 zero", v, 32'h0);
        do_rd(8'hB0, v); chk("R2 offset 3 zero", v, 32'h0);
        // R4 all inhibited: no pulses
        pulses = 0;
        for (int k = 0; k < 60; k++) begin @(negedge clk); if (irq != 0) pulses++; end
        chk("R4 no pulse while inhibited", pulses, 0);
        // R12 write to live count ignored
        do_wr(8'h80, 32'h0000_1234);
        do_rd(8'h80, v); chk("R12 count write ignored", v, 32'h0);
        // R9 / R3 base zero on ch0
        do_wr(8'h00 | 8'h10, 32'h0);
        gap(0, g); gap(0, g); chk("R9 pulse every tick div4", g, 4);
        div_sel = 1;
        gap(0, g); gap(0, g); chk("R3 tick every 8 clocks", g, 8);
        div_sel = 0;
        do_wr(8'h10, 32'h8000_0000);
        // R5 start ch1 with 5, R11 format
        do_wr(8'h50, 32'h0000_0005);
        do_rd(8'h40, v); chk("R5 load on start", v, 32'h0000_0005);
        gap(1, g); gap(1, g); chk("R8 period base+1 ticks", g, 24);
        // R6 stop with toggle kept
        do_wr(8'h50, 32'h8000_0002);
        do_wr(8'h50, 32'h0000_0002);
        wait_pulse(1);
        do_rd(8'h40, v); chk("R11 toggle in bit31 after expiry", v, 32'h8000_0002);
        do_wr(8'h50, 32'h8000_0002);
        do_rd(8'h40, v); chk("R6 stop keeps toggle", v, 32'h8000_0000);
        pulses = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (irq[1]) pulses++; end
        chk("R4 stopped channel silent", pulses, 0);
        // R7 base change while running
        do_wr(8'hD0, 32'd100);
        cyc(10);
        do_rd(8'hC0, v);
        do_wr(8'hD0, 32'd3);
        do_rd(8'hC0, v2);
        chk("R7 count not reloaded", (v2 <= v && v2 > 32'd50) ? 1 : 0, 1);
        do_rd(8'hD0, v); chk("R7 base updated", v, 32'd3);

        // Random phase, compared by the monitor
        for (int k = 0; k < 4000; k++) begin
            int r;
            @(negedge clk);
            wr_en = 0; rd_en = 0;
            r = $urandom % 100;
            addr = {2'($urandom % 4), 2'($urandom % 4), (($urandom % 16) == 0) ? 4'd8 : 4'd0};
            if (r < 25) begin
                wr_en = 1;
                wdata = {1'($urandom % 2), 31'($urandom % 24)};
            end else if (r < 60) begin
                rd_en = 1;
            end
            if ($urandom % 300 == 0) div_sel = ~div_sel;
        end
        @(negedge clk); wr_en = 0; rd_en = 0;
        cyc(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule